// File: doc/BRIEF.md
# Transmit Lockup Watchdog

This block watches a transmit engine for forward progress and, when the engine stays busy without moving on to a new descriptor, asks for a selective reset of the transmit unit. It is driven by a periodic check strobe. On each accepted check it samples the engine's busy flag and the index of the descriptor being worked on. It then compares that index with a copy kept from the previous check.

A check that shows progress re-arms the watchdog. Progress means the engine is idle, or the index has moved. A check that shows no progress advances a counter of stalled checks. Once that counter has reached its limit, the next stalled check emits a one-cycle reset request and bumps a lockup event count. The block then ignores check strobes for a settle window so that the engine can recover.

Each check takes one cycle, during which an interrupt-mask output is raised. This keeps interrupt-driven state from moving between the compare and the update.

Top module: `txwd_top`

## Requirements
- R1: A synchronous active-high `rst` clears the stored descriptor copy to 0, the stalled-check count to 0, the lockup count to 0 and the settle window, and drives `mask_irq` and `sel_reset` low.
- R2: A `chk_stb` sampled high on a clock edge while no check is running and no settle window is open starts a check. `tx_busy` and `tx_desc_idx` are captured on that edge, and `mask_irq` is high for exactly the following cycle.
- R3: A check that sees `tx_busy` low, or a captured index different from the stored copy, clears the stalled-check count and stores the captured index as the new copy, without a reset request.
- R4: A check that sees `tx_busy` high and the captured index equal to the stored copy, while the stalled-check count is below `TIMEOUT_CHECKS`, adds one to the count and does not request a reset.
- R5: A stalled check (as in R4) made when the count already equals `TIMEOUT_CHECKS` raises `sel_reset` for exactly one cycle, the cycle right after the `mask_irq` cycle. It also clears the count and keeps the stored copy. Starting from a cleared count, the reset comes on the (`TIMEOUT_CHECKS`+1)-th consecutive stalled check.
- R6: `lockup_cnt` rises by exactly one in the same cycle that `sel_reset` is high, and is otherwise unchanged.
- R7: Strobes sampled on the `SETTLE_CYC` clock edges that follow the edge issuing the reset are ignored. A strobe on the next edge after them is accepted.
- R8: A strobe sampled on the edge that ends a `mask_irq` cycle is ignored, so `mask_irq` is never high two cycles in a row.
- R9: An ignored strobe changes neither the stored copy nor the stalled-check count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_stb | input | 1 | Periodic check request |
| tx_busy | input | 1 | Transmit engine has work in flight |
| tx_desc_idx | input | IDX_W | Index of the descriptor the engine is on |
| mask_irq | output | 1 | High during the one-cycle check |
| sel_reset | output | 1 | One-cycle selective reset request for the transmit unit |
| lockup_cnt | output | CNT_W | Number of reset requests issued since reset |

## Verification
The main function is tried with four kinds of input pattern. Runs of identical busy checks show where the timeout lands. Runs broken by an index change show re-arming on progress, and runs broken by an idle check show that idleness counts as progress. Random mixes of busy and idle over a small index set make repeated stalls and changes frequent. Strobes placed on the last ignored edge and the first accepted edge of the settle window, plus back-to-back strobes, separate the ignore rules from the counting. A reset in the middle of a run shows that the stored copy restarts from index 0.

// File: rtl/txwd_pkg.sv
package txwd_pkg;
  typedef enum logic [0:0] {
    CHK_IDLE = 1'b0,
    CHK_EVAL = 1'b1
  } chk_state_t;

  function automatic logic no_progress(input logic busy, input logic same_idx);
    return busy & same_idx;
  endfunction
endpackage

// File: rtl/txwd_snapshot.sv
module txwd_snapshot #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             eval,
  input  logic             tx_busy,
  input  logic [IDX_W-1:0] tx_desc_idx,
  output logic             stalled
);
  import txwd_pkg::*;

  logic             busy_cap;
  logic [IDX_W-1:0] idx_cap;
  logic [IDX_W-1:0] snap_idx;

  // capture the engine state on the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cap <= 1'b0;
      idx_cap  <= '0;
    end else if (accept) begin
      busy_cap <= tx_busy;
      idx_cap  <= tx_desc_idx;
    end
  end

  assign stalled = no_progress(busy_cap, idx_cap == snap_idx);

  // the stored copy moves only on a progress check
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_idx <= '0;
    end else if (eval && !stalled) begin
      snap_idx <= idx_cap;
    end
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(eval) |-> $stable(snap_idx)); // R9
endmodule

// File: rtl/txwd_timer.sv
module txwd_timer #(
  parameter int TIMEOUT_CHECKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic eval,
  input  logic stalled,
  output logic fire
);
  localparam int TO_W = (TIMEOUT_CHECKS < 1) ? 1 : $clog2(TIMEOUT_CHECKS + 1);
  localparam logic [TO_W-1:0] TO_LIM = TO_W'(TIMEOUT_CHECKS);

  logic [TO_W-1:0] elapsed;
  logic            at_limit;

  assign at_limit = (elapsed == TO_LIM);
  assign fire     = eval && stalled && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
    end else if (eval) begin
      if (!stalled || at_limit) elapsed <= '0;
      else                      elapsed <= elapsed + 1'b1;
    end
  end

  AST_ELAPSED_RANGE: assert property (@(posedge clk) disable iff (rst)
    elapsed <= TO_LIM); // R4
  AST_ELAPSED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(eval) |-> $stable(elapsed)); // R9
endmodule

// File: rtl/txwd_settle.sv
module txwd_settle #(
  parameter int SETTLE_CYC = 5000,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  output logic             holdoff,
  output logic             sel_reset,
  output logic [CNT_W-1:0] lockup_cnt
);
  localparam int ST_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [ST_W-1:0] ST_LOAD = ST_W'(SETTLE_CYC);

  logic [ST_W-1:0] settle_cnt;

  assign holdoff = (settle_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt <= '0;
    end else if (fire) begin
      settle_cnt <= ST_LOAD;
    end else if (holdoff) begin
      settle_cnt <= settle_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_reset  <= 1'b0;
      lockup_cnt <= '0;
    end else begin
      sel_reset <= fire;
      if (fire) lockup_cnt <= lockup_cnt + 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sel_reset |=> !sel_reset); // R5
  AST_COUNT_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    (lockup_cnt != $past(lockup_cnt)) |-> sel_reset); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    sel_reset |-> (lockup_cnt == $past(lockup_cnt) + 1'b1)); // R6
endmodule

// File: rtl/txwd_top.sv
module txwd_top #(
  parameter int IDX_W          = 8,
  parameter int TIMEOUT_CHECKS = 3,
  parameter int SETTLE_CYC     = 5000,
  parameter int CNT_W          = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_stb,
  input  logic             tx_busy,
  input  logic [IDX_W-1:0] tx_desc_idx,
  output logic             mask_irq,
  output logic             sel_reset,
  output logic [CNT_W-1:0] lockup_cnt
);
  import txwd_pkg::*;

  chk_state_t state;
  logic       accept;
  logic       eval;
  logic       stalled;
  logic       fire;
  logic       holdoff;

  assign eval   = (state == CHK_EVAL);
  assign accept = chk_stb && !eval && !holdoff;

  always_ff @(posedge clk) begin
    if (rst) state <= CHK_IDLE;
    else     state <= accept ? CHK_EVAL : CHK_IDLE;
  end

  assign mask_irq = eval;

  txwd_snapshot #(.IDX_W(IDX_W)) u_snap (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .eval        (eval),
    .tx_busy     (tx_busy),
    .tx_desc_idx (tx_desc_idx),
    .stalled     (stalled)
  );

  txwd_timer #(.TIMEOUT_CHECKS(TIMEOUT_CHECKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .eval    (eval),
    .stalled (stalled),
    .fire    (fire)
  );

  txwd_settle #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_settle (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .holdoff    (holdoff),
    .sel_reset  (sel_reset),
    .lockup_cnt (lockup_cnt)
  );

  AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mask_irq |=> !mask_irq); // R8
  AST_RESET_AFTER_MASK: assert property (@(posedge clk) disable iff (rst)
    sel_reset |-> $past(mask_irq)); // R5
  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    holdoff |=> !mask_irq); // R7
  AST_IDLE_NO_CHECK: assert property (@(posedge clk) disable iff (rst)
    !chk_stb |=> !mask_irq); // R2
endmodule

// File: tb/txwd_top_tb_top.sv
module txwd_top_tb_top;
  localparam int IDX_W  = 8;
  localparam int TO     = 3;
  localparam int SETTLE = 40;
  localparam int CNT_W  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             chk_stb = 1'b0;
  logic             tx_busy = 1'b0;
  logic [IDX_W-1:0] tx_desc_idx = '0;
  logic             mask_irq;
  logic             sel_reset;
  logic [CNT_W-1:0] lockup_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state
  logic [IDX_W-1:0] m_snap    = '0;
  int               m_elapsed = 0;
  int               m_lock    = 0;

  always #2 clk = ~clk;

  txwd_top #(.IDX_W(IDX_W), .TIMEOUT_CHECKS(TO), .SETTLE_CYC(SETTLE), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .chk_stb(chk_stb), .tx_busy(tx_busy),
    .tx_desc_idx(tx_desc_idx), .mask_irq(mask_irq), .sel_reset(sel_reset),
    .lockup_cnt(lockup_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_stall(input bit busy, input logic [IDX_W-1:0] idx,
                                  input logic [IDX_W-1:0] snap);
    return busy && (idx == snap);
  endfunction

  function automatic bit will_fire(input bit stall, input int elapsed);
    return stall && (elapsed == TO);
  endfunction

  task automatic model_reset();
    m_snap = '0; m_elapsed = 0; m_lock = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; chk_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one accepted check; caller is at a negedge with no window open
  task automatic do_check(input bit busy, input logic [IDX_W-1:0] idx,
                          input bit wait_settle, output bit fired);
    bit stall, efire;
    stall = is_stall(busy, idx, m_snap);
    efire = will_fire(stall, m_elapsed);
    chk_stb = 1'b1; tx_busy = busy; tx_desc_idx = idx;
    @(negedge clk);
    chk_stb = 1'b0; tx_busy = $urandom_range(0, 1); tx_desc_idx = IDX_W'($urandom);
    check(mask_irq == 1'b1, "R2 mask_irq during check", mask_irq, 1);
    check(sel_reset == 1'b0, "R2 no pulse in mask cycle", sel_reset, 0);
    @(negedge clk);
    if (!stall) begin
      m_snap = idx; m_elapsed = 0;
    end else if (efire) begin
      m_elapsed = 0; m_lock++;
    end else begin
      m_elapsed++;
    end
    check(mask_irq == 1'b0, "R8 mask_irq one cycle", mask_irq, 0);
    check(sel_reset == efire, stall ? "R4/R5 stalled check pulse" : "R3 progress no pulse",
          sel_reset, efire);
    check(lockup_cnt == CNT_W'(m_lock), "R6 lockup count", lockup_cnt, m_lock);
    fired = efire;
    if (efire && wait_settle) repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit f;
    void'($urandom(32'h5EED_0042));
    do_reset();
    @(negedge clk);
    // R1: reset state at ports
    check(mask_irq == 0, "R1 mask_irq after reset", mask_irq, 0);
    check(sel_reset == 0, "R1 sel_reset after reset", sel_reset, 0);
    check(lockup_cnt == 0, "R1 lockup_cnt after reset", lockup_cnt, 0);

    // R1/R4/R5: snapshot restarts at 0, so busy on index 0 is a stall
    for (int i = 0; i < TO; i++) begin
      do_check(1'b1, 8'd0, 1'b1, f);
      check(f == 0, "R4 early stall silent", f, 0);
    end
    do_check(1'b1, 8'd0, 1'b0, f);
    check(f == 1, "R5 fire on stall TO+1", f, 1);

    // R7 / R9: strobe on the last ignored edge of the window
    repeat (SETTLE - 1) @(negedge clk);
    chk_stb = 1'b1; tx_busy = 1'b1; tx_desc_idx = 8'd0;
    @(negedge clk);
    check(mask_irq == 0, "R7 strobe in settle ignored", mask_irq, 0);
    @(negedge clk);
    chk_stb = 1'b0;
    check(mask_irq == 1, "R7 first strobe after settle accepted", mask_irq, 1);
    @(negedge clk);
    m_elapsed++;  // that accepted check was a stall on index 0
    check(sel_reset == 0, "R9 ignored strobe not counted", sel_reset, 0);
    for (int i = 1; i < TO; i++) do_check(1'b1, 8'd0, 1'b1, f);
    do_check(1'b1, 8'd0, 1'b1, f);
    check(f == 1, "R9 count resumes from accepted checks only", f, 1);

    // R8: back-to-back strobes, second lands on the evaluation edge
    chk_stb = 1'b1; tx_busy = 1'b0; tx_desc_idx = 8'd7;
    @(negedge clk);
    check(mask_irq == 1, "R2 first of pair accepted", mask_irq, 1);
    @(negedge clk);
    chk_stb = 1'b0;
    check(mask_irq == 0, "R8 second strobe ignored", mask_irq, 0);
    m_snap = 8'd7; m_elapsed = 0;

    // R3: index change re-arms
    do_check(1'b1, 8'd7, 1'b1, f);
    do_check(1'b1, 8'd7, 1'b1, f);
    do_check(1'b1, 8'd9, 1'b1, f);
    check(f == 0, "R3 index change no pulse", f, 0);
    for (int i = 0; i < TO; i++) do_check(1'b1, 8'd9, 1'b1, f);
    check(f == 0, "R3 count restarted after change", f, 0);
    // R3: idle check re-arms
    do_check(1'b0, 8'd9, 1'b1, f);
    for (int i = 0; i < TO; i++) do_check(1'b1, 8'd9, 1'b1, f);
    check(f == 0, "R3 idle check restarts count", f, 0);
    do_check(1'b1, 8'd9, 1'b1, f);
    check(f == 1, "R5 fire after idle re-arm", f, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit b;
      logic [IDX_W-1:0] ix;
      b  = ($urandom_range(0, 9) < 8);
      ix = ($urandom_range(0, 3) == 0) ? IDX_W'($urandom_range(0, 3)) : m_snap;
      do_check(b, ix, 1'b1, f);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    // R1: reset mid-run clears count and copy
    do_reset();
    @(negedge clk);
    check(lockup_cnt == 0, "R1 lockup_cnt cleared mid-run", lockup_cnt, 0);
    for (int i = 0; i < TO; i++) do_check(1'b1, 8'd0, 1'b1, f);
    do_check(1'b1, 8'd0, 1'b1, f);
    check(f == 1, "R1 copy restarts at index 0", f, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule